// File: doc/BRIEF.md
# Fetch Next-Address Predictor

This unit sits in the fetch stage and picks the address to fetch in the next cycle. It looks up the current fetch address in a small direct-mapped target cache. A hit marks the instruction as a branch and gives the target that the branch went to the last time it was taken. A static direction policy, chosen by a two-bit input at run time, then decides whether that target is used or whether fetch moves on sequentially by one 4-byte instruction.

The execute stage feeds resolved branches back through a resolve port. Every resolved taken branch fills or refreshes its cache entry. A resolved branch flagged as mispredicted raises a flush request in that same cycle. The flush makes the pipeline drop the younger instructions, which costs two bubbles in a five-stage pipe. It also steers the next fetch address to the correct path, in place of any prediction.

Top module: `fetch_nextpc_pred`

## Requirements
- R1: Reset clears every valid bit in the target cache, so after reset every fetch address misses, even in the always-taken policy.
- R2: On a cache miss with no flush, pred_taken is 0 and next_pc equals fetch_pc + 4, in every policy and for either hint value.
- R3: A resolve with rs_valid=1 and rs_taken=1 writes rs_target for rs_pc at the clock edge. From the next cycle a lookup of rs_pc hits and returns that target.
- R4: A later taken resolve of the same branch address replaces the stored target with the new one.
- R5: Policy code 2'b00 (never taken) predicts not taken even on a hit, so next_pc is fetch_pc + 4.
- R6: Policy code 2'b01 (always taken) predicts taken on every hit, so next_pc is the stored target.
- R7: Policy code 2'b10 (backward) predicts taken on a hit only when the stored target is strictly lower than fetch_pc. A target equal to or above fetch_pc counts as forward and is predicted not taken.
- R8: Policy code 2'b11 (hint) uses hint_bit as the direction on a hit: 1 means taken, 0 means not taken.
- R9: When rs_valid=1 and rs_mispredict=1, flush is 1 in that cycle and pred_taken is 0. next_pc is rs_target if rs_taken=1, or rs_pc + 4 if rs_taken=0, whatever the lookup would have predicted. In the following cycle without a mispredict, flush is 0.
- R10: A resolve with rs_taken=0 does not write the cache, so a later lookup of that address still misses.
- R11: The cache is direct-mapped with 16 entries indexed by address bits [5:2]. A taken resolve whose address has the same index but a different tag evicts the older branch, and that branch then misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fetch_pc | input | 32 | Address being fetched this cycle |
| hint_bit | input | 1 | Pre-decoded direction hint of the fetched instruction |
| mode | input | 2 | Direction policy: 00 never, 01 always, 10 backward, 11 hint |
| rs_valid | input | 1 | A resolved branch is presented |
| rs_pc | input | 32 | Address of the resolved branch |
| rs_taken | input | 1 | Actual direction of the resolved branch |
| rs_target | input | 32 | Actual target of the resolved branch |
| rs_mispredict | input | 1 | The resolved branch was mispredicted |
| next_pc | output | 32 | Address to fetch in the next cycle |
| pred_taken | output | 1 | The lookup predicted a taken branch |
| flush | output | 1 | Drop younger fetched instructions |

## Verification
next_pc, pred_taken and flush depend combinationally on the lookup and resolve inputs, so each is due in the same cycle as its stimulus. A cache write lands on the rising edge that ends the resolve cycle and can only be seen by a lookup driven in a later cycle. The driver applies each cycle's inputs on the falling edge and queues that cycle's expected outputs. The monitor compares them 1 ns later, well before the next rising edge, so every write-then-read check puts the lookup at least one full cycle after the resolve.

// File: rtl/fnp_pkg.sv
package fnp_pkg;
  typedef enum logic [1:0] {
    DIR_NEVER    = 2'b00,
    DIR_ALWAYS   = 2'b01,
    DIR_BACKWARD = 2'b10,
    DIR_HINT     = 2'b11
  } dir_mode_e;
endpackage

// File: rtl/fnp_target_cache.sv
module fnp_target_cache #(
  parameter int PC_W    = 32,
  parameter int ENTRIES = 16,
  parameter int OFS_W   = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] rd_pc,
  output logic            hit,
  output logic [PC_W-1:0] rd_tgt,
  input  logic            wr_en,
  input  logic [PC_W-1:0] wr_pc,
  input  logic [PC_W-1:0] wr_tgt
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int TAG_W = PC_W - IDX_W - OFS_W;

  logic [ENTRIES-1:0] vld_vec;
  logic [TAG_W-1:0]   tag_arr [ENTRIES];
  logic [PC_W-1:0]    tgt_arr [ENTRIES];

  logic [IDX_W-1:0] wr_idx, rd_idx;
  logic [TAG_W-1:0] wr_tag, rd_tag;

  assign wr_idx = wr_pc[OFS_W +: IDX_W];
  assign wr_tag = wr_pc[PC_W-1 -: TAG_W];
  assign rd_idx = rd_pc[OFS_W +: IDX_W];
  assign rd_tag = rd_pc[PC_W-1 -: TAG_W];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic            we;
    logic            v_q, v_d;
    logic [TAG_W-1:0] t_q;
    logic [PC_W-1:0]  g_q;

    assign we = wr_en && (wr_idx == IDX_W'(e));

    always_comb begin
      v_d = v_q;
      if (we) v_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) v_q <= 1'b0;
      else        v_q <= v_d;
    end

    // payload flops carry no reset; valid bit qualifies them
    always_ff @(posedge clk) begin
      if (we) begin
        t_q <= wr_tag;
        g_q <= wr_tgt;
      end
    end

    assign vld_vec[e] = v_q;
    assign tag_arr[e] = t_q;
    assign tgt_arr[e] = g_q;
  end

  assign hit    = vld_vec[rd_idx] && (tag_arr[rd_idx] == rd_tag);
  assign rd_tgt = tgt_arr[rd_idx];

  AST_FILL_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en && rst_n) && (rd_pc == $past(wr_pc))) |-> (hit && (rd_tgt == $past(wr_tgt)))); // R3
endmodule

// File: rtl/fnp_direction.sv
module fnp_direction #(
  parameter int PC_W = 32
) (
  input  fnp_pkg::dir_mode_e mode,
  input  logic               hint_bit,
  input  logic [PC_W-1:0]    pc,
  input  logic [PC_W-1:0]    tgt,
  output logic               taken
);
  import fnp_pkg::*;

  always_comb begin
    unique case (mode)
      DIR_NEVER:    taken = 1'b0;
      DIR_ALWAYS:   taken = 1'b1;
      DIR_BACKWARD: taken = (tgt < pc);
      DIR_HINT:     taken = hint_bit;
      default:      taken = 1'b0;
    endcase
  end
endmodule

// File: rtl/fetch_nextpc_pred.sv
module fetch_nextpc_pred #(
  parameter int PC_W       = 32,
  parameter int ENTRIES    = 16,
  parameter int INST_BYTES = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] fetch_pc,
  input  logic            hint_bit,
  input  logic [1:0]      mode,
  input  logic            rs_valid,
  input  logic [PC_W-1:0] rs_pc,
  input  logic            rs_taken,
  input  logic [PC_W-1:0] rs_target,
  input  logic            rs_mispredict,
  output logic [PC_W-1:0] next_pc,
  output logic            pred_taken,
  output logic            flush
);
  import fnp_pkg::*;

  localparam int OFS_W = $clog2(INST_BYTES);
  localparam logic [PC_W-1:0] STEP = PC_W'(INST_BYTES);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q, rsync_d;
  logic       rst_int_n;

  always_comb rsync_d = {rsync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= rsync_d;
  end
  assign rst_int_n = rsync_q[1];

  logic            btb_hit;
  logic [PC_W-1:0] btb_tgt;
  logic            dir_taken;
  logic            fill_en;

  assign fill_en = rs_valid && rs_taken;

  fnp_target_cache #(
    .PC_W    (PC_W),
    .ENTRIES (ENTRIES),
    .OFS_W   (OFS_W)
  ) u_cache (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .rd_pc  (fetch_pc),
    .hit    (btb_hit),
    .rd_tgt (btb_tgt),
    .wr_en  (fill_en),
    .wr_pc  (rs_pc),
    .wr_tgt (rs_target)
  );

  fnp_direction #(.PC_W(PC_W)) u_dir (
    .mode     (dir_mode_e'(mode)),
    .hint_bit (hint_bit),
    .pc       (fetch_pc),
    .tgt      (btb_tgt),
    .taken    (dir_taken)
  );

  logic [PC_W-1:0] seq_pc, fix_pc;
  logic            redirect;

  always_comb begin
    seq_pc     = fetch_pc + STEP;
    fix_pc     = rs_taken ? rs_target : (rs_pc + STEP);
    redirect   = rs_valid && rs_mispredict;
    pred_taken = !redirect && btb_hit && dir_taken;
    flush      = redirect;
    if (redirect)        next_pc = fix_pc;
    else if (pred_taken) next_pc = btb_tgt;
    else                 next_pc = seq_pc;
  end

  AST_SEQ_ON_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!pred_taken && !flush) |-> (next_pc == fetch_pc + STEP)); // R2
  AST_TAKEN_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_int_n)
    pred_taken |-> (btb_hit && next_pc == btb_tgt)); // R6
  AST_NEVER_MODE: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mode == 2'b00) |-> !pred_taken); // R5
  AST_BACKWARD_ONLY: assert property (@(posedge clk) disable iff (!rst_int_n)
    ((mode == 2'b10) && pred_taken) |-> (next_pc < fetch_pc)); // R7
  AST_REDIRECT_FALLTHRU: assert property (@(posedge clk) disable iff (!rst_int_n)
    (flush && !rs_taken) |-> (!pred_taken && next_pc == rs_pc + STEP)); // R9
endmodule

// File: tb/sim_fetch_nextpc_pred.sv
`timescale 1ns/100ps
module sim_fetch_nextpc_pred;
  typedef struct {
    logic [31:0] npc;
    logic        tk;
    logic        fl;
    string       req;
  } exp_t;

  logic        clk;
  logic        rst_n;
  logic [31:0] fetch_pc;
  logic        hint_bit;
  logic [1:0]  mode;
  logic        rs_valid;
  logic [31:0] rs_pc;
  logic        rs_taken;
  logic [31:0] rs_target;
  logic        rs_mispredict;
  logic [31:0] next_pc;
  logic        pred_taken;
  logic        flush;

  exp_t q[$];
  int   n_run  = 0;
  int   n_fail = 0;
  bit   done   = 0;

  fetch_nextpc_pred u0 (
    .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .hint_bit(hint_bit), .mode(mode),
    .rs_valid(rs_valid), .rs_pc(rs_pc), .rs_taken(rs_taken), .rs_target(rs_target),
    .rs_mispredict(rs_mispredict), .next_pc(next_pc), .pred_taken(pred_taken), .flush(flush)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // driver: one cycle of stimulus, optionally queueing its expected result
  task automatic cyc(input logic [1:0] m, input logic [31:0] pc, input logic h,
                     input logic rv, input logic [31:0] rpc, input logic rt,
                     input logic [31:0] rtg, input logic rm,
                     input logic chk, input logic [31:0] enpc, input logic etk,
                     input logic efl, input string r);
    exp_t e;
    @(negedge clk);
    mode = m; fetch_pc = pc; hint_bit = h;
    rs_valid = rv; rs_pc = rpc; rs_taken = rt; rs_target = rtg; rs_mispredict = rm;
    if (chk) begin
      e.npc = enpc; e.tk = etk; e.fl = efl; e.req = r;
      q.push_back(e);
    end
  endtask

  task automatic look(input logic [1:0] m, input logic [31:0] pc, input logic h,
                      input logic [31:0] enpc, input logic etk, input string r);
    cyc(m, pc, h, 1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 1'b1, enpc, etk, 1'b0, r);
  endtask

  task automatic fill(input logic [31:0] rpc, input logic [31:0] rtg);
    cyc(2'b00, 32'h0000_0F00, 1'b0, 1'b1, rpc, 1'b1, rtg, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, "");
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    rs_valid = 1'b0; rs_mispredict = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // monitor: compares each queued item shortly after its drive edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_run++;
        if (next_pc !== e.npc || pred_taken !== e.tk || flush !== e.fl) begin
          n_fail++;
          $display("FAIL %s: next_pc=%h pred_taken=%b flush=%b expected next_pc=%h pred_taken=%b flush=%b",
                   e.req, next_pc, pred_taken, flush, e.npc, e.tk, e.fl);
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; fetch_pc = '0; hint_bit = 1'b0; mode = 2'b00;
    rs_valid = 1'b0; rs_pc = '0; rs_taken = 1'b0; rs_target = '0; rs_mispredict = 1'b0;
    do_reset();

    // R1: empty cache after reset, always-taken still falls through
    look(2'b01, 32'h100, 1'b0, 32'h104, 1'b0, "R1");
    // R10: not-taken resolve does not fill; R2 miss in same cycle
    cyc(2'b01, 32'h300, 1'b1, 1'b1, 32'h200, 1'b0, 32'h80, 1'b0, 1'b1, 32'h304, 1'b0, 1'b0, "R2");
    look(2'b01, 32'h200, 1'b0, 32'h204, 1'b0, "R10");
    // R3: taken resolve fills, next cycle hits
    cyc(2'b01, 32'h400, 1'b0, 1'b1, 32'h200, 1'b1, 32'h80, 1'b0, 1'b1, 32'h404, 1'b0, 1'b0, "R2");
    look(2'b01, 32'h200, 1'b0, 32'h80, 1'b1, "R3");
    look(2'b01, 32'h200, 1'b1, 32'h80, 1'b1, "R6");
    // R5: never-taken ignores a hit
    look(2'b00, 32'h200, 1'b1, 32'h204, 1'b0, "R5");
    // R7: backward/forward/equal
    look(2'b10, 32'h200, 1'b0, 32'h80, 1'b1, "R7");
    fill(32'h210, 32'h300);
    fill(32'h220, 32'h220);
    look(2'b10, 32'h210, 1'b0, 32'h214, 1'b0, "R7");
    look(2'b10, 32'h220, 1'b0, 32'h224, 1'b0, "R7");
    look(2'b01, 32'h220, 1'b0, 32'h220, 1'b1, "R6");
    // R8: hint policy
    look(2'b11, 32'h200, 1'b1, 32'h80, 1'b1, "R8");
    look(2'b11, 32'h200, 1'b0, 32'h204, 1'b0, "R8");
    look(2'b11, 32'h500, 1'b1, 32'h504, 1'b0, "R2");
    // R4: target refresh
    fill(32'h200, 32'h40);
    look(2'b01, 32'h200, 1'b0, 32'h40, 1'b1, "R4");
    // R11: same index 0, different tag evicts
    fill(32'h240, 32'h10);
    look(2'b01, 32'h200, 1'b0, 32'h204, 1'b0, "R11");
    look(2'b01, 32'h240, 1'b0, 32'h10, 1'b1, "R11");
    // R9: mispredict redirect overrides a hit
    cyc(2'b01, 32'h240, 1'b0, 1'b1, 32'h600, 1'b1, 32'h700, 1'b1, 1'b1, 32'h700, 1'b0, 1'b1, "R9");
    cyc(2'b01, 32'h210, 1'b0, 1'b1, 32'h680, 1'b0, 32'h900, 1'b1, 1'b1, 32'h684, 1'b0, 1'b1, "R9");
    look(2'b01, 32'h100, 1'b0, 32'h104, 1'b0, "R9");
    // R1: reset mid-run clears filled entries
    do_reset();
    look(2'b01, 32'h220, 1'b0, 32'h224, 1'b0, "R1");
    look(2'b01, 32'h210, 1'b0, 32'h214, 1'b0, "R1");

    repeat (3) @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule